// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

This block sits between a bank of timer channels and the interrupt fabric. Each channel delivers match events that become interrupts in one of three ways. The first is a line chosen by the channel's route field. The second is a fixed line pair used when legacy replacement is on. The third is a 32-bit memory-write message presented on a simple request/address/data handshake. Level-triggered channels keep a status bit and hold their line until software clears the bit by writing ones to it. Edge-triggered channels emit a single-cycle pulse.

Two external legacy interrupt inputs also pass through this block: an interval-timer input and a real-time-clock input. While legacy replacement is off they drive fixed lines. While it is on, timer channels 0 and 1 take over those lines, the external inputs are blocked, and an enable output tells the interval timer to stop. The clock input's level is latched all the time, so that the line shows the right value again as soon as legacy mode ends.

Top module: `timer_irq_router`

## Requirements
- R1: Outside legacy mode, an active channel drives the line whose index is its `ch_route` field; the line reflects an event two clock edges after the event is sampled.
- R2: With `legacy_en` high, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold; other channels keep their route fields.
- R3: A level-mode channel (`ch_level`=1) sets its `int_status` bit one edge after an event and holds its line high until the bit is cleared.
- R4: An edge-mode channel (`ch_level`=0) drives its line high for exactly one cycle per event and never sets its status bit.
- R5: With `sts_clr_valid` high, each `sts_clr_mask` bit at 1 clears the same `int_status` bit and its level line; mask bits at 0 change nothing. An event in the same cycle wins over the clear.
- R6: A channel that is disabled (`ch_enable`=0), or any channel while `glb_en`=0, has its status bit cleared and its line low, and an event on it delivers nothing.
- R7: A channel with `ch_msg_en`=1 turns an event into a message request. `msg_addr` is bits 63:32 of its `ch_msg_word` and `msg_data` is bits 31:0. `msg_req` rises two edges after the event, holds with stable address and data until `msg_ack`, and pending channels are served lowest index first. Such a channel drives no line.
- R8: Setting `ch_msg_en` on a channel clears its status bit and drops its line.
- R9: Outside legacy mode, `pit_irq_in` drives line 0 and `rtc_irq_in` drives line 8, two edges after sampling. Inside legacy mode both inputs are blocked from the lines.
- R10: `pit_enable` is high in reset and follows the inverse of `legacy_en` one edge later.
- R11: The clock input level is latched even in legacy mode and is zero after reset. On leaving legacy mode, line 8 returns to the latched level one edge later.
- R12: When several sources target one line, the line is the OR of them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable for event delivery |
| legacy_en | input | 1 | Legacy replacement routing mode |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_level | input | NUM_CH | 1 = level triggered, 0 = edge triggered |
| ch_msg_en | input | NUM_CH | Deliver events by memory-write message |
| ch_route | input | NUM_CH*ROUTE_W | Per-channel line index, channel c at [c*ROUTE_W +: ROUTE_W] |
| ch_msg_word | input | NUM_CH*64 | Per-channel message word: address high half, data low half |
| ch_event | input | NUM_CH | One-cycle match event per channel |
| sts_clr_valid | input | 1 | Status clear strobe |
| sts_clr_mask | input | NUM_CH | Write-one-to-clear mask |
| pit_irq_in | input | 1 | External interval-timer interrupt level |
| rtc_irq_in | input | 1 | External real-time-clock interrupt level |
| msg_ack | input | 1 | Bus accepts the current message |
| irq_lines | output | NUM_LINES | Interrupt output lines |
| int_status | output | NUM_CH | Level-mode interrupt status |
| pit_enable | output | 1 | Enable for the external interval timer |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
A status bit is due one edge after the event or clear is sampled. Lines, message requests and passthrough levels are due two edges after their cause, because a channel or input register sits in front of the line or message register. `pit_enable` and the legacy blocking of lines follow `legacy_en` after a single edge. Inputs change just after a falling edge and outputs are sampled on the next falling edge. The bench steps an exact number of edges before every directed check, and its reference model advances once per rising edge, so each comparison lands in the cycle where the result is due.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int MSG_AW = 32;
  localparam int MSG_DW = 32;
  localparam int MSG_WORD_W = MSG_AW + MSG_DW;

  // Message word layout: address in the upper half, data in the lower half.
  typedef struct packed {
    logic [MSG_AW-1:0] addr;
    logic [MSG_DW-1:0] data;
  } msg_word_t;

endpackage

// File: rtl/irq_chan_slice.sv
module irq_chan_slice (
  input  logic clk,
  input  logic rst,
  input  logic ch_event,
  input  logic ch_enable,
  input  logic glb_en,
  input  logic level_mode,
  input  logic msg_en,
  input  logic clr_hit,
  output logic status_q,
  output logic msg_evt,
  output logic line_drive
);

  logic line_ok;
  logic pulse_q;

  // A channel may drive a wire only when it is live and not sending messages.
  assign line_ok = ch_enable & glb_en & ~msg_en;
  assign msg_evt = ch_event & ch_enable & glb_en & msg_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= line_ok & ch_event & ~level_mode;
      if (!line_ok) begin
        status_q <= 1'b0;
      end else if (ch_event && level_mode) begin
        status_q <= 1'b1;
      end else if (clr_hit) begin
        status_q <= 1'b0;
      end
    end
  end

  assign line_drive = line_ok & (level_mode ? status_q : pulse_q);

endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux #(
  parameter int NUM_CH    = 3,
  parameter int NUM_LINES = 16,
  parameter int PIT_LINE  = 0,
  parameter int RTC_LINE  = 8,
  localparam int ROUTE_W  = $clog2(NUM_LINES)
) (
  input  logic [NUM_CH-1:0]         drive,
  input  logic [NUM_CH*ROUTE_W-1:0] route,
  input  logic                      legacy_en,
  input  logic                      pit_q,
  input  logic                      rtc_q,
  output logic [NUM_LINES-1:0]      line_next
);

  localparam logic [ROUTE_W-1:0] PIT_IDX = ROUTE_W'(PIT_LINE);
  localparam logic [ROUTE_W-1:0] RTC_IDX = ROUTE_W'(RTC_LINE);

  logic [ROUTE_W-1:0] tgt [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_tgt
    if (c == 0) begin : g_pit_slot
      assign tgt[c] = legacy_en ? PIT_IDX : route[c*ROUTE_W +: ROUTE_W];
    end else if (c == 1) begin : g_rtc_slot
      assign tgt[c] = legacy_en ? RTC_IDX : route[c*ROUTE_W +: ROUTE_W];
    end else begin : g_plain
      assign tgt[c] = route[c*ROUTE_W +: ROUTE_W];
    end
  end

  always_comb begin
    line_next = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (drive[c]) begin
        line_next[tgt[c]] = 1'b1;
      end
    end
    if (!legacy_en) begin
      line_next[PIT_IDX] = line_next[PIT_IDX] | pit_q;
      line_next[RTC_IDX] = line_next[RTC_IDX] | rtc_q;
    end
  end

endmodule

// File: rtl/irq_legacy_ctl.sv
module irq_legacy_ctl (
  input  logic clk,
  input  logic rst,
  input  logic legacy_en,
  input  logic pit_irq_in,
  input  logic rtc_irq_in,
  output logic pit_q,
  output logic rtc_q,
  output logic pit_enable
);

  // The clock level is kept whatever the mode, so leaving legacy mode
  // shows the current level again at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      pit_q      <= 1'b0;
      rtc_q      <= 1'b0;
      pit_enable <= 1'b1;
    end else begin
      pit_q      <= pit_irq_in;
      rtc_q      <= rtc_irq_in;
      pit_enable <= ~legacy_en;
    end
  end

endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
  import irq_router_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            msg_evt,
  input  logic [NUM_CH*MSG_WORD_W-1:0] words,
  input  logic                         msg_ack,
  output logic                         msg_req,
  output logic [MSG_AW-1:0]            msg_addr,
  output logic [MSG_DW-1:0]            msg_data
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  msg_word_t         word_arr [NUM_CH];
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] grant;
  logic [IDX_W-1:0]  pick_idx;
  logic              any_pend;
  logic              slot_free;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_words
    assign word_arr[c] = words[c*MSG_WORD_W +: MSG_WORD_W];
  end

  // Lowest pending index wins.
  always_comb begin
    pick_idx = '0;
    any_pend = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (pend_q[c]) begin
        pick_idx = IDX_W'(c);
        any_pend = 1'b1;
      end
    end
    slot_free = ~msg_req | msg_ack;
    grant = '0;
    if (slot_free && any_pend) begin
      grant[pick_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      msg_req  <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
    end else begin
      pend_q <= (pend_q & ~grant) | msg_evt;
      if (slot_free) begin
        msg_req <= any_pend;
        if (any_pend) begin
          msg_addr <= word_arr[pick_idx].addr;
          msg_data <= word_arr[pick_idx].data;
        end
      end
    end
  end

endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int NUM_LINES = 16,
  parameter int PIT_LINE  = 0,
  parameter int RTC_LINE  = 8,
  localparam int ROUTE_W  = $clog2(NUM_LINES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         glb_en,
  input  logic                         legacy_en,
  input  logic [NUM_CH-1:0]            ch_enable,
  input  logic [NUM_CH-1:0]            ch_level,
  input  logic [NUM_CH-1:0]            ch_msg_en,
  input  logic [NUM_CH*ROUTE_W-1:0]    ch_route,
  input  logic [NUM_CH*MSG_WORD_W-1:0] ch_msg_word,
  input  logic [NUM_CH-1:0]            ch_event,
  input  logic                         sts_clr_valid,
  input  logic [NUM_CH-1:0]            sts_clr_mask,
  input  logic                         pit_irq_in,
  input  logic                         rtc_irq_in,
  input  logic                         msg_ack,
  output logic [NUM_LINES-1:0]         irq_lines,
  output logic [NUM_CH-1:0]            int_status,
  output logic                         pit_enable,
  output logic                         msg_req,
  output logic [MSG_AW-1:0]            msg_addr,
  output logic [MSG_DW-1:0]            msg_data
);

  logic [NUM_CH-1:0]    drive;
  logic [NUM_CH-1:0]    msg_evt;
  logic [NUM_LINES-1:0] line_next;
  logic                 pit_q;
  logic                 rtc_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_chan_slice u_slice (
      .clk       (clk),
      .rst       (rst),
      .ch_event  (ch_event[c]),
      .ch_enable (ch_enable[c]),
      .glb_en    (glb_en),
      .level_mode(ch_level[c]),
      .msg_en    (ch_msg_en[c]),
      .clr_hit   (sts_clr_valid & sts_clr_mask[c]),
      .status_q  (int_status[c]),
      .msg_evt   (msg_evt[c]),
      .line_drive(drive[c])
    );
  end

  irq_legacy_ctl u_legacy (
    .clk       (clk),
    .rst       (rst),
    .legacy_en (legacy_en),
    .pit_irq_in(pit_irq_in),
    .rtc_irq_in(rtc_irq_in),
    .pit_q     (pit_q),
    .rtc_q     (rtc_q),
    .pit_enable(pit_enable)
  );

  irq_line_mux #(
    .NUM_CH   (NUM_CH),
    .NUM_LINES(NUM_LINES),
    .PIT_LINE (PIT_LINE),
    .RTC_LINE (RTC_LINE)
  ) u_mux (
    .drive    (drive),
    .route    (ch_route),
    .legacy_en(legacy_en),
    .pit_q    (pit_q),
    .rtc_q    (rtc_q),
    .line_next(line_next)
  );

  irq_msg_arb #(
    .NUM_CH(NUM_CH)
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .msg_evt (msg_evt),
    .words   (ch_msg_word),
    .msg_ack (msg_ack),
    .msg_req (msg_req),
    .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lines <= '0;
    end else begin
      irq_lines <= line_next;
    end
  end

endmodule

// File: rtl/timer_irq_router_chk.sv
module timer_irq_router_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              glb_en,
  input logic              legacy_en,
  input logic [NUM_CH-1:0] ch_msg_en,
  input logic [NUM_CH-1:0] ch_event,
  input logic              sts_clr_valid,
  input logic [NUM_CH-1:0] sts_clr_mask,
  input logic [NUM_CH-1:0] int_status,
  input logic              pit_enable,
  input logic              msg_req,
  input logic              msg_ack,
  input logic [31:0]       msg_addr,
  input logic [31:0]       msg_data
);

  // R10
  legacy_pit_low_chk: assert property (@(posedge clk) disable iff (rst)
    legacy_en |=> !pit_enable);

  // R7
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data)));

  // R6
  glb_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> (int_status == '0));

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_clr_valid && ch_event == '0) |=> ((int_status & $past(sts_clr_mask)) == '0));

  // R8
  msg_mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_msg_en != '0) |=> ((int_status & $past(ch_msg_en)) == '0));

endmodule

bind timer_irq_router timer_irq_router_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .glb_en       (glb_en),
  .legacy_en    (legacy_en),
  .ch_msg_en    (ch_msg_en),
  .ch_event     (ch_event),
  .sts_clr_valid(sts_clr_valid),
  .sts_clr_mask (sts_clr_mask),
  .int_status   (int_status),
  .pit_enable   (pit_enable),
  .msg_req      (msg_req),
  .msg_ack      (msg_ack),
  .msg_addr     (msg_addr),
  .msg_data     (msg_data)
);

// File: tb/tb_timer_irq_router.sv
module tb_timer_irq_router;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int NL  = 16;
  localparam int RW  = 4;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_en = 1'b0;
  logic legacy_en = 1'b0;
  logic [NCH-1:0] ch_enable = '0;
  logic [NCH-1:0] ch_level = '0;
  logic [NCH-1:0] ch_msg_en = '0;
  logic [NCH*RW-1:0] ch_route = '0;
  logic [NCH*64-1:0] ch_msg_word = '0;
  logic [NCH-1:0] ch_event = '0;
  logic sts_clr_valid = 1'b0;
  logic [NCH-1:0] sts_clr_mask = '0;
  logic pit_irq_in = 1'b0;
  logic rtc_irq_in = 1'b0;
  logic msg_ack = 1'b0;
  logic [NL-1:0] irq_lines;
  logic [NCH-1:0] int_status;
  logic pit_enable;
  logic msg_req;
  logic [31:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_irq_router #(.NUM_CH(NCH), .NUM_LINES(NL)) dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .legacy_en(legacy_en),
    .ch_enable(ch_enable), .ch_level(ch_level), .ch_msg_en(ch_msg_en),
    .ch_route(ch_route), .ch_msg_word(ch_msg_word), .ch_event(ch_event),
    .sts_clr_valid(sts_clr_valid), .sts_clr_mask(sts_clr_mask),
    .pit_irq_in(pit_irq_in), .rtc_irq_in(rtc_irq_in), .msg_ack(msg_ack),
    .irq_lines(irq_lines), .int_status(int_status), .pit_enable(pit_enable),
    .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [NL-1:0]  m_lines;
  bit [NCH-1:0] m_status, m_pulse, m_pend;
  bit           m_req, m_pitq, m_rtcq, m_pit_en;
  bit [31:0]    m_addr, m_data;

  always @(posedge clk) begin
    if (rst) begin
      m_lines = '0; m_status = '0; m_pulse = '0; m_pend = '0;
      m_req = 0; m_addr = '0; m_data = '0;
      m_pitq = 0; m_rtcq = 0; m_pit_en = 1;
    end else begin
      bit [NL-1:0] nl;
      bit [NCH-1:0] evt_msg;
      bit found;
      nl = '0;
      for (int c = 0; c < NCH; c++) begin
        bit ok;
        int t;
        ok = ch_enable[c] && glb_en && !ch_msg_en[c];
        if (ok && (ch_level[c] ? m_status[c] : m_pulse[c])) begin
          if (legacy_en && c == 0) t = 0;
          else if (legacy_en && c == 1) t = 8;
          else t = int'(ch_route[c*RW +: RW]);
          nl[t] = 1'b1;
        end
      end
      if (!legacy_en) begin
        nl[0] = nl[0] | m_pitq;
        nl[8] = nl[8] | m_rtcq;
      end
      m_lines = nl;
      if (!m_req || msg_ack) begin
        found = 0;
        for (int c = 0; c < NCH; c++) begin
          if (!found && m_pend[c]) begin
            found = 1;
            m_pend[c] = 1'b0;
            m_addr = ch_msg_word[c*64+32 +: 32];
            m_data = ch_msg_word[c*64 +: 32];
          end
        end
        m_req = found;
      end
      for (int c = 0; c < NCH; c++) begin
        bit ok;
        ok = ch_enable[c] && glb_en && !ch_msg_en[c];
        evt_msg[c] = ch_event[c] && ch_enable[c] && glb_en && ch_msg_en[c];
        m_pulse[c] = ok && ch_event[c] && !ch_level[c];
        if (!ok) m_status[c] = 1'b0;
        else if (ch_event[c] && ch_level[c]) m_status[c] = 1'b1;
        else if (sts_clr_valid && sts_clr_mask[c]) m_status[c] = 1'b0;
      end
      m_pend = m_pend | evt_msg;
      m_pitq = pit_irq_in;
      m_rtcq = rtc_irq_in;
      m_pit_en = !legacy_en;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 lines vs model", 64'(irq_lines), 64'(m_lines));
      chk("R3 status vs model", 64'(int_status), 64'(m_status));
      chk("R10 pit_enable vs model", 64'(pit_enable), 64'(m_pit_en));
      chk("R7 msg_req vs model", 64'(msg_req), 64'(m_req));
      if (m_req) chk("R7 msg word vs model", {msg_addr, msg_data}, {m_addr, m_data});
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(input logic [NCH-1:0] m);
    ch_event = m;
    step(1);
    ch_event = '0;
  endtask

  task automatic clr(input logic [NCH-1:0] m);
    sts_clr_valid = 1'b1;
    sts_clr_mask = m;
    step(1);
    sts_clr_valid = 1'b0;
    sts_clr_mask = '0;
  endtask

  task automatic set_route(input int c, input int r);
    ch_route[c*RW +: RW] = RW'(r);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    // Reset state
    chk("R10 reset pit_enable", 64'(pit_enable), 64'd1);
    chk("R11 reset lines", 64'(irq_lines), 64'd0);
    chk("R3 reset status", 64'(int_status), 64'd0);
    chk("R7 reset msg_req", 64'(msg_req), 64'd0);

    glb_en = 1'b1;
    ch_enable = 3'b111;
    set_route(0, 3); set_route(1, 4); set_route(2, 5);

    // R3 / R1: level channel 2 on route 5
    ch_level = 3'b100;
    fire(3'b100);
    chk("R3 status set", 64'(int_status), 64'h4);
    step(1);
    chk("R1 line from route field", 64'(irq_lines), 64'h20);
    step(3);
    chk("R3 level line held", 64'(irq_lines), 64'h20);

    // R5: zeros in mask ignored, ones clear
    clr(3'b011);
    chk("R5 zero mask bit keeps status", 64'(int_status), 64'h4);
    step(1);
    chk("R5 zero mask bit keeps line", 64'(irq_lines), 64'h20);
    clr(3'b100);
    chk("R5 status cleared", 64'(int_status), 64'h0);
    step(1);
    chk("R5 line dropped", 64'(irq_lines), 64'h0);

    // R4: edge channel 0 on route 3
    ch_level = 3'b000;
    fire(3'b001);
    chk("R4 edge sets no status", 64'(int_status), 64'h0);
    step(1);
    chk("R4 pulse high", 64'(irq_lines), 64'h8);
    step(1);
    chk("R4 pulse one cycle", 64'(irq_lines), 64'h0);

    // R12: two level channels share line 6
    ch_level = 3'b101;
    set_route(0, 6); set_route(2, 6);
    fire(3'b101);
    step(1);
    chk("R12 shared line high", 64'(irq_lines), 64'h40);
    clr(3'b001);
    chk("R12 one driver cleared", 64'(int_status), 64'h4);
    step(1);
    chk("R12 line stays by other driver", 64'(irq_lines), 64'h40);
    clr(3'b100);
    step(1);
    chk("R12 line low after both cleared", 64'(irq_lines), 64'h0);

    // R6: global disable and channel disable
    fire(3'b100);
    glb_en = 1'b0;
    step(1);
    chk("R6 global off clears status", 64'(int_status), 64'h0);
    step(1);
    chk("R6 global off drops line", 64'(irq_lines), 64'h0);
    fire(3'b100);
    step(1);
    chk("R6 event ignored when global off", 64'(irq_lines), 64'h0);
    chk("R6 status stays clear", 64'(int_status), 64'h0);
    glb_en = 1'b1;
    ch_enable = 3'b011;
    fire(3'b100);
    step(1);
    chk("R6 disabled channel delivers nothing", 64'(irq_lines), 64'h0);
    chk("R6 disabled channel status clear", 64'(int_status), 64'h0);
    ch_enable = 3'b111;

    // R8: enabling message mode drops line
    fire(3'b100);
    step(1);
    chk("R8 line before message mode", 64'(irq_lines), 64'h40);
    ch_msg_en = 3'b100;
    step(1);
    chk("R8 status cleared", 64'(int_status), 64'h0);
    step(1);
    chk("R8 line dropped", 64'(irq_lines), 64'h0);
    chk("R8 no message without event", 64'(msg_req), 64'd0);
    ch_msg_en = 3'b000;

    // R7: message delivery, two channels, ordered, held until ack
    ch_msg_word[0*64 +: 64] = {32'hFEE0_1000, 32'h0000_0041};
    ch_msg_word[1*64 +: 64] = {32'hFEE0_2000, 32'h0000_0042};
    ch_msg_en = 3'b011;
    ch_level = 3'b011;
    fire(3'b011);
    chk("R7 request not yet", 64'(msg_req), 64'd0);
    step(1);
    chk("R7 first request", {31'd0, msg_req, msg_addr}, {31'd0, 1'b1, 32'hFEE0_1000});
    chk("R7 first data", 64'(msg_data), 64'h41);
    chk("R7 no line for message", 64'(irq_lines), 64'h0);
    step(3);
    chk("R7 held without ack", {31'd0, msg_req, msg_addr}, {31'd0, 1'b1, 32'hFEE0_1000});
    msg_ack = 1'b1;
    step(1);
    msg_ack = 1'b0;
    chk("R7 second request", {31'd0, msg_req, msg_addr}, {31'd0, 1'b1, 32'hFEE0_2000});
    chk("R7 second data", 64'(msg_data), 64'h42);
    msg_ack = 1'b1;
    step(1);
    msg_ack = 1'b0;
    chk("R7 request released", 64'(msg_req), 64'd0);
    ch_msg_en = 3'b000;
    ch_level = 3'b000;

    // R9 / R10 / R11: passthrough and legacy entry/exit
    pit_irq_in = 1'b1;
    step(2);
    chk("R9 pit passes to line 0", 64'(irq_lines), 64'h1);
    rtc_irq_in = 1'b1;
    step(2);
    chk("R9 rtc passes to line 8", 64'(irq_lines), 64'h101);
    legacy_en = 1'b1;
    step(1);
    chk("R10 pit_enable low in legacy", 64'(pit_enable), 64'd0);
    chk("R9 inputs blocked in legacy", 64'(irq_lines), 64'h0);
    rtc_irq_in = 1'b0;
    step(2);
    rtc_irq_in = 1'b1;
    step(2);
    chk("R9 rtc still blocked", 64'(irq_lines), 64'h0);
    pit_irq_in = 1'b0;
    step(1);
    legacy_en = 1'b0;
    step(1);
    chk("R10 pit_enable high after exit", 64'(pit_enable), 64'd1);
    chk("R11 line 8 restored to latched level", 64'(irq_lines), 64'h100);
    rtc_irq_in = 1'b0;
    step(2);
    chk("R11 line 8 follows rtc", 64'(irq_lines), 64'h0);

    // R2: legacy routes for channels 0 and 1
    set_route(0, 3); set_route(1, 4);
    legacy_en = 1'b1;
    ch_level = 3'b011;
    fire(3'b011);
    step(1);
    chk("R2 legacy routes to lines 0 and 8", 64'(irq_lines), 64'h101);
    clr(3'b011);
    legacy_en = 1'b0;
    step(2);
    chk("R2 lines low after clear", 64'(irq_lines), 64'h0);

    step(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule